// File: doc/BRIEF.md
# Posted Memory Write Target Acceptor

This block sits on the target side of a bus bridge. It watches a simplified PCI target port for the start of a transaction. Memory write and memory write-and-invalidate bursts are claimed and written into a posted write queue, so the initiator can finish without waiting for the far bus. Every other command is left alone.

A burst is claimed only when the queue can hold the header entry and a minimum reserve of data words. The block then takes one Dword on every clock in which the initiator is ready. It ends the burst with a disconnect on the data phase that carries the last Dword before an address boundary, or the last Dword the queue can hold. The cache line boundary applies to write-and-invalidate and the 4 KB page boundary applies to plain write. When there is too little room, the block signals a retry.

Each queue entry is tagged as a header (command and address) or as data (byte enables and Dword). The final data entry of a burst carries an end marker.

Top module: `pw_target_acceptor`

## Requirements
- R1: Only command codes 4'b0111 (memory write) and 4'b1111 (memory write-and-invalidate), sampled on C/BE# in the address phase, are claimed. Any other command produces no DEVSEL#, no STOP# and no queue push.
- R2: A claim asserts DEVSEL# and TRDY# (both active low) in the same cycle. They become visible after the second rising edge following the address-phase edge, which is medium decode timing. TRDY# is never low while DEVSEL# is high.
- R3: A burst is claimed only if `q_free`, sampled one edge after the address phase, is at least 9. That covers one header entry plus 8 data Dwords.
- R4: After a claim, TRDY# stays low until the final data phase. One Dword is taken on every edge where IRDY# and TRDY# are both low, including after an initiator stall.
- R5: Queue entries are 38 bits wide and appear with `q_push` one edge after the edge on which they were sampled. A header entry is bit37=1, bit36=0, bits35:32=command, bits31:0=start address. A data entry is bit37=0, bit36=end marker, bits35:32=C/BE# as driven, bits31:0=AD. The header precedes the data of its burst.
- R6: For write-and-invalidate, the last accepted Dword is the last one in the cache line. The line size comes from `line_dw` (a power of two, in Dwords). For plain write, the last accepted Dword is the last one in the aligned 4 KB page. STOP# is driven low together with TRDY# on that data phase.
- R7: A burst accepts at most `q_free`−1 data Dwords (`q_free` sampled at the claim edge). STOP# is driven low with TRDY# on the phase that carries the last of them.
- R8: If `q_free` is below 9, DEVSEL# and STOP# go low while TRDY# stays high, which is a retry. Nothing is pushed. Both are released one clock after FRAME# is sampled high.
- R9: A data phase with FRAME# high and IRDY# low is the initiator's last. Its Dword is accepted and carries the end marker.
- R10: One clock after the final data phase completes, DEVSEL#, TRDY# and STOP# are all high and the block accepts a new transaction.
- R11: While `rst` is high, DEVSEL#, TRDY# and STOP# are high and `q_push` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_l | input | 1 | FRAME#, active low |
| irdy_l | input | 1 | IRDY#, active low |
| ad | input | 32 | Address/data bus |
| cbe_l | input | 4 | Command / byte enables, active low |
| line_dw | input | CL_W | Cache line size in Dwords, power of two, static |
| q_free | input | FREE_W | Free entries in the posted write queue |
| devsel_l | output | 1 | DEVSEL#, active low |
| trdy_l | output | 1 | TRDY#, active low |
| stop_l | output | 1 | STOP#, active low |
| q_push | output | 1 | Queue write strobe |
| q_entry | output | 38 | Queue entry (header or data) |

## Verification
Two pairs of end conditions can fall in the same cycle. The first is the initiator's own last data phase landing exactly on the cache line boundary. This is provoked by a 16-Dword write-and-invalidate burst that starts on a 16-Dword line. The second is the buffer-full limit coinciding with the boundary. This is provoked by a queue with exactly 9 free entries and an 8-Dword line. In both cases the scoreboard expects the same number of Dwords as either condition alone would give, with exactly one end marker on the last entry. A further check confirms that DEVSEL#, TRDY# and STOP# are all released on the following clock.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;
  localparam int         ENTRY_W        = 38;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_RETRY
  } pw_state_e;

  typedef struct packed {
    logic        hdr;
    logic        last;
    logic [3:0]  tag;
    logic [31:0] payload;
  } pw_entry_t;

endpackage

// File: rtl/pw_cmd_decode.sv
module pw_cmd_decode
  import pw_pkg::*;
(
  input  logic [3:0] cmd,
  output logic       is_post,
  output logic       is_mwi
);
  // Posting applies to the two memory write flavours only.
  always_comb begin
    is_mwi  = (cmd == CMD_MEM_WR_INV);
    is_post = (cmd == CMD_MEM_WR) || is_mwi;
  end
endmodule

// File: rtl/pw_boundary_check.sv
module pw_boundary_check #(
  parameter int CL_W         = 8,
  parameter int PAGE_DW_BITS = 10
) (
  input  logic [29:0]     dw_addr,
  input  logic            use_line,
  input  logic [CL_W-1:0] line_dw,
  output logic            last_dw
);
  localparam int LINE_BITS = (CL_W < 30) ? CL_W : 30;

  logic [LINE_BITS-1:0] line_mask;
  logic                 line_end;
  logic                 page_end;

  // A zero line size falls back to the page window.
  always_comb begin
    line_mask = LINE_BITS'(line_dw - 1'b1);
    line_end  = ((dw_addr[LINE_BITS-1:0] & line_mask) == line_mask);
    page_end  = &dw_addr[PAGE_DW_BITS-1:0];
    last_dw   = (use_line && (line_dw != '0)) ? line_end : page_end;
  end
endmodule

// File: rtl/pw_queue_packer.sv
module pw_queue_packer
  import pw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               push_hdr,
  input  logic               push_data,
  input  logic               last,
  input  logic [3:0]         cmd,
  input  logic [31:0]        addr,
  input  logic [3:0]         be_l,
  input  logic [31:0]        data,
  output logic               q_push,
  output logic [ENTRY_W-1:0] q_entry
);
  pw_entry_t entry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_push  <= 1'b0;
      entry_q <= '0;
    end else begin
      q_push <= push_hdr | push_data;
      if (push_hdr) begin
        entry_q <= '{hdr: 1'b1, last: 1'b0, tag: cmd, payload: addr};
      end else if (push_data) begin
        entry_q <= '{hdr: 1'b0, last: last, tag: be_l, payload: data};
      end
    end
  end

  assign q_entry = entry_q;
endmodule

// File: rtl/pw_target_acceptor.sv
module pw_target_acceptor
  import pw_pkg::*;
#(
  parameter int FREE_W       = 8,
  parameter int CL_W         = 8,
  parameter int PAGE_DW_BITS = 10,
  parameter int MIN_RESERVE  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_l,
  input  logic               irdy_l,
  input  logic [31:0]        ad,
  input  logic [3:0]         cbe_l,
  input  logic [CL_W-1:0]    line_dw,
  input  logic [FREE_W-1:0]  q_free,
  output logic               devsel_l,
  output logic               trdy_l,
  output logic               stop_l,
  output logic               q_push,
  output logic [ENTRY_W-1:0] q_entry
);
  localparam logic [FREE_W-1:0] ADMIT_MIN = FREE_W'(MIN_RESERVE + 1);
  localparam logic [FREE_W-1:0] TWO_LEFT  = FREE_W'(2);

  pw_state_e         state_q;
  logic              frame_prev_q;
  logic              devsel_q, trdy_q, stop_q;
  logic [31:0]       addr_q, addr_next;
  logic [3:0]        cmd_q;
  logic              mwi_q;
  logic [FREE_W-1:0] space_q;

  logic is_post, is_mwi;
  logic bnd_cur, bnd_next;
  logic start, xfer, final_ph, admit;
  logic push_hdr, push_data;

  pw_cmd_decode u_dec (
    .cmd     (cbe_l),
    .is_post (is_post),
    .is_mwi  (is_mwi)
  );

  assign addr_next = addr_q + 32'd4;

  // Boundary test for the phase about to be offered at claim time.
  pw_boundary_check #(.CL_W(CL_W), .PAGE_DW_BITS(PAGE_DW_BITS)) u_bnd_cur (
    .dw_addr  (addr_q[31:2]),
    .use_line (mwi_q),
    .line_dw  (line_dw),
    .last_dw  (bnd_cur)
  );

  // Boundary test for the phase that follows a completed transfer.
  pw_boundary_check #(.CL_W(CL_W), .PAGE_DW_BITS(PAGE_DW_BITS)) u_bnd_next (
    .dw_addr  (addr_next[31:2]),
    .use_line (mwi_q),
    .line_dw  (line_dw),
    .last_dw  (bnd_next)
  );

  always_comb begin
    start     = (state_q == ST_IDLE) && !frame_l && frame_prev_q;
    admit     = (q_free >= ADMIT_MIN);
    xfer      = (state_q == ST_DATA) && trdy_q && !irdy_l;
    final_ph  = xfer && (frame_l || stop_q);
    push_hdr  = (state_q == ST_DECODE) && admit;
    push_data = xfer;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      frame_prev_q <= 1'b1;
      devsel_q     <= 1'b0;
      trdy_q       <= 1'b0;
      stop_q       <= 1'b0;
      addr_q       <= '0;
      cmd_q        <= '0;
      mwi_q        <= 1'b0;
      space_q      <= '0;
    end else begin
      frame_prev_q <= frame_l;
      unique case (state_q)
        ST_IDLE: begin
          if (start && is_post) begin
            addr_q  <= ad;
            cmd_q   <= cbe_l;
            mwi_q   <= is_mwi;
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          devsel_q <= 1'b1;
          if (admit) begin
            trdy_q  <= 1'b1;
            stop_q  <= bnd_cur;
            space_q <= q_free - 1'b1;
            state_q <= ST_DATA;
          end else begin
            stop_q  <= 1'b1;
            state_q <= ST_RETRY;
          end
        end
        ST_DATA: begin
          if (xfer) begin
            if (final_ph) begin
              devsel_q <= 1'b0;
              trdy_q   <= 1'b0;
              stop_q   <= 1'b0;
              state_q  <= ST_IDLE;
            end else begin
              addr_q  <= addr_next;
              space_q <= space_q - 1'b1;
              stop_q  <= (space_q == TWO_LEFT) || bnd_next;
            end
          end
        end
        ST_RETRY: begin
          if (frame_l) begin
            devsel_q <= 1'b0;
            stop_q   <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign devsel_l = ~devsel_q;
  assign trdy_l   = ~trdy_q;
  assign stop_l   = ~stop_q;

  pw_queue_packer u_pack (
    .clk       (clk),
    .rst       (rst),
    .push_hdr  (push_hdr),
    .push_data (push_data),
    .last      (final_ph),
    .cmd       (cmd_q),
    .addr      (addr_q),
    .be_l      (cbe_l),
    .data      (ad),
    .q_push    (q_push),
    .q_entry   (q_entry)
  );
endmodule

// File: rtl/pw_target_acceptor_chk.sv
module pw_target_acceptor_chk #(
  parameter int FREE_W      = 8,
  parameter int MIN_RESERVE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_l,
  input logic              devsel_l,
  input logic              trdy_l,
  input logic              stop_l,
  input logic [FREE_W-1:0] q_free,
  input logic              q_push,
  input logic [37:0]       q_entry
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R2: ready never offered without a claim
  p_trdy_claimed_r2: assert property (@(posedge clk) disable iff (rst)
    !trdy_l |-> !devsel_l);

  // R2: medium timing, two edges after the address-phase edge
  p_medium_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q == 2'd3) && $fell(devsel_l) |-> (!$past(frame_l, 2) && $past(frame_l, 3)));

  // R3: a header is only written when the reserve was present
  p_admit_reserve_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q != 2'd0) && q_push && q_entry[37] |-> ($past(q_free) >= FREE_W'(MIN_RESERVE + 1)));

  // R8: a retry never writes the queue
  p_retry_no_push_r8: assert property (@(posedge clk) disable iff (rst)
    (!stop_l && trdy_l) |-> !q_push);

  // R1: STOP# only within a claimed transaction
  p_stop_claimed_r1: assert property (@(posedge clk) disable iff (rst)
    !stop_l |-> !devsel_l);

  // R10: the end marker coincides with released target signals
  p_release_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    q_push && q_entry[36] |-> (devsel_l && trdy_l && stop_l));
endmodule

bind pw_target_acceptor pw_target_acceptor_chk #(
  .FREE_W      (FREE_W),
  .MIN_RESERVE (MIN_RESERVE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frame_l  (frame_l),
  .devsel_l (devsel_l),
  .trdy_l   (trdy_l),
  .stop_l   (stop_l),
  .q_free   (q_free),
  .q_push   (q_push),
  .q_entry  (q_entry)
);

// File: tb/pw_target_acceptor_test.sv
module pw_target_acceptor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_l = 1'b1;
  logic        irdy_l = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_l = 4'hF;
  logic [7:0]  line_dw = 8'd8;
  logic [7:0]  q_free = 8'd32;
  logic        devsel_l, trdy_l, stop_l, q_push;
  logic [37:0] q_entry;

  int total = 0;
  int bad = 0;
  string cur_tag = "R5";
  logic [37:0] exp_q[$];

  always #2 clk = ~clk;

  pw_target_acceptor uut (
    .clk(clk), .rst(rst), .frame_l(frame_l), .irdy_l(irdy_l), .ad(ad),
    .cbe_l(cbe_l), .line_dw(line_dw), .q_free(q_free),
    .devsel_l(devsel_l), .trdy_l(trdy_l), .stop_l(stop_l),
    .q_push(q_push), .q_entry(q_entry)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [31:0] dat(input logic [31:0] a, input int i);
    return (a ^ (32'h01010101 * i)) + 32'hA5000000;
  endfunction

  function automatic logic [3:0] be_of(input int i);
    return 4'(i * 3);
  endfunction

  function automatic int exp_accept(input logic [3:0] cmd, input logic [31:0] a, input int n, input int free);
    int dw, win, acc;
    if (!(cmd == 4'h7 || cmd == 4'hF) || free < 9) return 0;
    dw  = int'(a >> 2);
    win = (cmd == 4'hF) ? (int'(line_dw) - (dw % int'(line_dw))) : (1024 - (dw % 1024));
    acc = n;
    if (win < acc) acc = win;
    if (free - 1 < acc) acc = free - 1;
    return acc;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && q_push) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected push"}, 64'(q_entry), 64'h0);
      end else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        check(q_entry == e, {cur_tag, " queue entry"}, 64'(q_entry), 64'(e));
      end
    end
  end

  task automatic burst(input logic [3:0] cmd, input logic [31:0] a, input int n,
                       input int stall_at, input int free, input string tag);
    int acc, i, cyc, seen_dev;
    bit claim, post, t, s, d, done, stalled;
    post  = (cmd == 4'h7 || cmd == 4'hF);
    claim = post && (free >= 9);
    acc   = exp_accept(cmd, a, n, free);
    cur_tag = tag;
    q_free = 8'(free);
    if (claim) begin
      exp_q.push_back({1'b1, 1'b0, cmd, a});
      for (int k = 0; k < acc; k++)
        exp_q.push_back({1'b0, (k == acc - 1), be_of(k), dat(a + 32'(4 * k), k)});
    end
    @(posedge clk); #1;
    frame_l = 1'b0; ad = a; cbe_l = cmd;
    @(posedge clk); #1;
    irdy_l = 1'b0; ad = dat(a, 0); cbe_l = be_of(0);
    if (n == 1) frame_l = 1'b1;
    i = 0; cyc = 0; seen_dev = -1; done = 1'b0; stalled = 1'b0;
    while (!done && cyc < 12 + 2 * n) begin
      @(negedge clk);
      t = trdy_l; s = stop_l; d = devsel_l;
      if (!d && seen_dev < 0) begin
        seen_dev = cyc;
        check(cyc == 1, "R2 DEVSEL# medium timing cycle", 64'(cyc), 64'd1);
        check(t == !claim, "R2 TRDY# with DEVSEL# (R3 admission)", 64'(t), 64'(!claim));
      end
      @(posedge clk); #1;
      cyc++;
      if (!t && !irdy_l) begin
        if (frame_l || !s) begin
          frame_l = 1'b1; irdy_l = 1'b1; done = 1'b1;
        end else begin
          i++;
          ad = dat(a + 32'(4 * i), i); cbe_l = be_of(i);
          if (i == stall_at && !stalled) begin
            irdy_l = 1'b1; stalled = 1'b1;
          end else if (i == n - 1) begin
            frame_l = 1'b1;
          end
        end
      end else if (irdy_l) begin
        irdy_l = 1'b0;
        if (i == n - 1) frame_l = 1'b1;
      end else if (!s && t) begin
        frame_l = 1'b1;
        @(posedge clk); #1;
        irdy_l = 1'b1; done = 1'b1;
      end
    end
    if (!done) begin
      frame_l = 1'b1;
      @(posedge clk); #1;
      irdy_l = 1'b1;
    end
    @(negedge clk);
    check(devsel_l && trdy_l && stop_l, {tag, " R10 released after final phase"},
          64'({devsel_l, trdy_l, stop_l}), 64'h7);
    if (!post)
      check(seen_dev < 0, "R1 other command not claimed", 64'(seen_dev), 64'hFFFFFFFFFFFFFFFF);
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R4 watchdog expired", 64'd1, 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(devsel_l && trdy_l && stop_l && !q_push, "R11 reset state",
          64'({devsel_l, trdy_l, stop_l, q_push}), 64'hE);
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(posedge clk);

    burst(4'h7, 32'h0000_1000, 4, -1, 32, "R9");          // plain burst, initiator ends
    burst(4'h7, 32'h0000_2040, 6, 3, 32, "R4");           // initiator stall mid-burst
    burst(4'hF, 32'h0000_0010, 10, -1, 32, "R6");         // line boundary after 4
    burst(4'h7, 32'h0000_0FF8, 5, -1, 32, "R6");          // 4 KB boundary after 2
    burst(4'h7, 32'h0000_3000, 20, -1, 12, "R7");         // buffer full after 11
    burst(4'h7, 32'h0000_4000, 4, -1, 8, "R8");           // retry, too little room
    burst(4'h3, 32'h0000_5000, 3, -1, 32, "R1");          // not a memory write
    burst(4'hF, 32'h0000_001C, 3, -1, 32, "R6");          // first phase at line end
    burst(4'hF, 32'h0000_0100, 12, -1, 9, "R7");          // full and line end coincide
    line_dw = 8'd16;
    burst(4'hF, 32'h0000_0400, 16, -1, 32, "R6");         // initiator end on line end
    burst(4'h7, 32'h0000_6000, 1, -1, 9, "R3");           // exact admission threshold
    burst(4'h7, 32'h0000_7000, 2, -1, 32, "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule